// File: doc/BRIEF.md
# SIMD Immediate Pattern Expander

This block turns the 13-bit immediate of a vector load-immediate instruction into a full 128-bit vector register value. The upper bits of the immediate select a pattern generator. The generator builds one element, which is 8, 16, 32 or 64 bits wide. That element is then copied into every lane of the vector.

The available patterns are:
- a plain or sign-extended constant;
- a byte placed at a chosen offset inside a zero element;
- a byte placed above a run of ones;
- a 64-bit mask with one byte per immediate bit;
- compact single- and double-precision floating-point constants.

An encoding that names no pattern raises an illegal flag and produces an all-zero vector.

The issue logic presents the immediate together with a valid strobe. By default the result, its valid and the illegal flag come out of one register stage, one clock later. A parameter removes that stage and makes the path purely combinational. The registered result holds its value until the next strobe.

Top module: `simd_imm_expand`

## Requirements
- R1: Mode bits imm[12:10] = 000 copy imm[7:0] into all sixteen byte lanes. imm[9:8] have no effect.
- R2: Mode bits imm[12:10] = 001, 010 or 011 sign-extend imm[9:0], using imm[9] as the sign. The result is copied as 16-bit, 32-bit or 64-bit elements respectively.
- R3: Codes imm[12:8] = 10000, 10001, 10010 and 10011 place imm[7:0] at bit 0, 8, 16 or 24 of a 32-bit element. All other bits of the element are zero.
- R4: Codes 10100 and 10101 place imm[7:0] at bit 0 or bit 8 of a 16-bit element. All other bits are zero.
- R5: Code 10110 forms the 32-bit element {16'h0, imm[7:0], 8'hFF}. Code 10111 forms {8'h0, imm[7:0], 16'hFFFF}.
- R6: Code 11000 copies imm[7:0] into every byte lane, the same result as R1.
- R7: Code 11001 forms a 64-bit element. Byte k of that element is 8'hFF when imm[k] is 1 and 8'h00 otherwise.
- R8: Code 11010 forms the 32-bit element {imm[7], ~imm[6], {5{imm[6]}}, imm[5:0], 19'b0}. Code 11011 copies the same 32-bit value into the low half of 64-bit elements and sets the high half to zero.
- R9: Code 11100 forms the 64-bit element {imm[7], ~imm[6], {8{imm[6]}}, imm[5:0], 48'b0}.
- R10: Codes 11101, 11110 and 11111 raise the illegal flag together with out_valid and drive an all-zero vector. Legal codes leave the flag low.
- R11: With the output register present, out_valid, out_vec and out_illegal follow an accepted strobe by exactly one clock, and back-to-back strobes give back-to-back results. A synchronous active-high reset clears out_valid and out_illegal, and a strobe presented while reset is high is dropped.
- R12: With the output register present, out_vec does not change in a cycle that follows a clock edge at which in_valid was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Immediate strobe |
| in_imm | input | 13 | Instruction immediate |
| out_valid | output | 1 | Result valid |
| out_vec | output | 128 | Expanded vector |
| out_illegal | output | 1 | Encoding names no pattern (qualified by out_valid) |

## Verification
The only state in the block is the output register, so a fault in the pattern or replication logic shows up in the very next valid result. Such a fault appears as a wrong lane, or as a value that repeats at the wrong element period. Each pattern is therefore checked against a hand-computed 128-bit value, using immediates with asymmetric bits so that a swapped offset or a wrong width gives a different vector.

A stale or unqualified register shows up one cycle after the strobe drops. That is where the hold and valid checks sample. Reset and back-to-back strobes are covered by directed cases.

// File: rtl/simd_imm_pkg.sv
package simd_imm_pkg;

   // element width chosen by the pattern decoder
   typedef enum logic [1:0] {
      EW_B = 2'd0,
      EW_H = 2'd1,
      EW_W = 2'd2,
      EW_D = 2'd3
   } elem_w_e;

   typedef struct packed {
      logic [63:0] elem;
      elem_w_e     ew;
      logic        bad;
   } pat_t;

endpackage

// File: rtl/sie_decode.sv
module sie_decode
   import simd_imm_pkg::*;
#(
   parameter int IMM_W = 13
) (
   input  logic [IMM_W-1:0] imm,
   output pat_t             pat
);

   localparam int SX_PAD = 64 - 10;

   generate
      if (IMM_W != 13) begin : g_bad_imm_w
         $error("sie_decode: IMM_W must be 13");
      end
   endgenerate

   logic [7:0]  lo_byte;
   logic [63:0] sext;
   logic [31:0] fp_single;
   logic [63:0] fp_double;
   logic [63:0] bit_mask;

   assign lo_byte   = imm[7:0];
   assign sext      = {{SX_PAD{imm[9]}}, imm[9:0]};
   assign fp_single = {imm[7], ~imm[6], {5{imm[6]}}, imm[5:0], 19'b0};
   assign fp_double = {imm[7], ~imm[6], {8{imm[6]}}, imm[5:0], 48'b0};

   always_comb begin
      for (int k = 0; k < 8; k++) begin
         bit_mask[8*k +: 8] = {8{lo_byte[k]}};
      end
   end

   always_comb begin
      pat      = '0;
      pat.ew   = EW_B;
      if (!imm[12]) begin
         unique case (imm[11:10])
            2'b00: begin pat.elem = 64'(lo_byte); pat.ew = EW_B; end
            2'b01: begin pat.elem = sext;         pat.ew = EW_H; end
            2'b10: begin pat.elem = sext;         pat.ew = EW_W; end
            default: begin pat.elem = sext;       pat.ew = EW_D; end
         endcase
      end else begin
         unique case (imm[11:8])
            4'h0: begin pat.elem = 64'(lo_byte);                 pat.ew = EW_W; end
            4'h1: begin pat.elem = 64'(lo_byte) << 8;            pat.ew = EW_W; end
            4'h2: begin pat.elem = 64'(lo_byte) << 16;           pat.ew = EW_W; end
            4'h3: begin pat.elem = 64'(lo_byte) << 24;           pat.ew = EW_W; end
            4'h4: begin pat.elem = 64'(lo_byte);                 pat.ew = EW_H; end
            4'h5: begin pat.elem = 64'(lo_byte) << 8;            pat.ew = EW_H; end
            4'h6: begin pat.elem = 64'({lo_byte, 8'hFF});        pat.ew = EW_W; end
            4'h7: begin pat.elem = 64'({lo_byte, 16'hFFFF});     pat.ew = EW_W; end
            4'h8: begin pat.elem = 64'(lo_byte);                 pat.ew = EW_B; end
            4'h9: begin pat.elem = bit_mask;                     pat.ew = EW_D; end
            4'hA: begin pat.elem = 64'(fp_single);               pat.ew = EW_W; end
            4'hB: begin pat.elem = 64'(fp_single);               pat.ew = EW_D; end
            4'hC: begin pat.elem = fp_double;                    pat.ew = EW_D; end
            default: begin pat.elem = '0; pat.ew = EW_B; pat.bad = 1'b1; end
         endcase
      end
   end

endmodule

// File: rtl/sie_replicate.sv
module sie_replicate
   import simd_imm_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic [63:0]      elem,
   input  elem_w_e          ew,
   output logic [VEC_W-1:0] vec
);

   localparam int NBYTES = VEC_W / 8;

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         localparam int OFS_H = 8 * (g % 2);
         localparam int OFS_W = 8 * (g % 4);
         localparam int OFS_D = 8 * (g % 8);
         always_comb begin
            unique case (ew)
               EW_B:    vec[8*g +: 8] = elem[7:0];
               EW_H:    vec[8*g +: 8] = elem[OFS_H +: 8];
               EW_W:    vec[8*g +: 8] = elem[OFS_W +: 8];
               default: vec[8*g +: 8] = elem[OFS_D +: 8];
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/sie_outstage.sv
module sie_outstage #(
   parameter int VEC_W   = 128,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] in_vec,
   input  logic             in_bad,
   output logic             out_valid,
   output logic [VEC_W-1:0] out_vec,
   output logic             out_bad
);

   generate
      if (OUT_REG) begin : g_reg
         logic             v_q;
         logic             bad_q;
         logic [VEC_W-1:0] vec_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               v_q   <= 1'b0;
               bad_q <= 1'b0;
            end else begin
               v_q   <= in_valid;
               bad_q <= in_valid & in_bad;
            end
         end

         // data register has no reset; it only loads on an accepted strobe
         always_ff @(posedge clk) begin
            if (in_valid && !rst) begin
               vec_q <= in_vec;
            end
         end

         assign out_valid = v_q;
         assign out_bad   = bad_q;
         assign out_vec   = vec_q;
      end else begin : g_comb
         assign out_valid = in_valid;
         assign out_bad   = in_valid & in_bad;
         assign out_vec   = in_vec;
      end
   endgenerate

endmodule

// File: rtl/simd_imm_expand.sv
module simd_imm_expand
   import simd_imm_pkg::*;
#(
   parameter int IMM_W   = 13,
   parameter int VEC_W   = 128,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IMM_W-1:0] in_imm,
   output logic             out_valid,
   output logic [VEC_W-1:0] out_vec,
   output logic             out_illegal
);

   generate
      if ((VEC_W % 64) != 0 || VEC_W < 64) begin : g_bad_vec_w
         $error("simd_imm_expand: VEC_W must be a nonzero multiple of 64");
      end
   endgenerate

   pat_t             pat;
   logic [VEC_W-1:0] vec_c;

   sie_decode #(.IMM_W(IMM_W)) u_dec (
      .imm (in_imm),
      .pat (pat)
   );

   sie_replicate #(.VEC_W(VEC_W)) u_rep (
      .elem (pat.elem),
      .ew   (pat.ew),
      .vec  (vec_c)
   );

   sie_outstage #(.VEC_W(VEC_W), .OUT_REG(OUT_REG)) u_out (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_vec    (vec_c),
      .in_bad    (pat.bad),
      .out_valid (out_valid),
      .out_vec   (out_vec),
      .out_bad   (out_illegal)
   );

endmodule

// File: rtl/sie_checker.sv
module sie_checker #(
   parameter int IMM_W   = 13,
   parameter int VEC_W   = 128,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [IMM_W-1:0] in_imm,
   input logic             out_valid,
   input logic [VEC_W-1:0] out_vec,
   input logic             out_illegal
);

   localparam int NBYTES = VEC_W / 8;

   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> (out_vec == '0)); // R10

   AST_ILLEGAL_QUAL: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> out_valid); // R10

   generate
      if (OUT_REG) begin : g_reg
         logic past_ok;
         always_ff @(posedge clk) begin
            if (rst) past_ok <= 1'b0;
            else     past_ok <= 1'b1;
         end

         AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
            past_ok |-> (out_valid == $past(in_valid))); // R11

         AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
            (past_ok && !$past(in_valid)) |-> $stable(out_vec)); // R12

         AST_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(in_valid) && ($past(in_imm[12:10]) == 3'b111)
             && ($past(in_imm[9:8]) != 2'b00)) |-> out_illegal); // R10

         AST_BYTE_MODE: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(in_valid) && ($past(in_imm[12:10]) == 3'b000))
            |-> (out_vec == {NBYTES{$past(in_imm[7:0])}})); // R1
      end else begin : g_comb
         AST_COMB_VALID: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid); // R11
      end
   endgenerate

endmodule

bind simd_imm_expand sie_checker #(
   .IMM_W   (IMM_W),
   .VEC_W   (VEC_W),
   .OUT_REG (OUT_REG)
) u_sie_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .in_imm      (in_imm),
   .out_valid   (out_valid),
   .out_vec     (out_vec),
   .out_illegal (out_illegal)
);

// File: tb/tb_simd_imm_expand.sv
module tb_simd_imm_expand;

   localparam int NV = 25;

   // immediate, expected vector, expected illegal flag, requirement tag
   localparam logic [12:0] IMM_T [NV] = '{
      13'h0012, 13'h0312, 13'h0712, 13'h0812, 13'h0FFF,
      13'h0A00, 13'h10A5, 13'h11A5, 13'h12A5, 13'h13A5,
      13'h14A5, 13'h15A5, 13'h16A5, 13'h17A5, 13'h18A5,
      13'h19A5, 13'h1900, 13'h1A70, 13'h1A80, 13'h1B70,
      13'h1C70, 13'h1C80, 13'h1DFF, 13'h1E12, 13'h1F34
   };
   localparam logic [127:0] EXP_T [NV] = '{
      {16{8'h12}},                 // R1
      {16{8'h12}},                 // R1 imm[9:8] ignored
      {8{16'hFF12}},               // R2 negative 16-bit
      {4{32'h0000_0012}},          // R2
      {2{64'hFFFF_FFFF_FFFF_FFFF}},// R2 64-bit
      {4{32'hFFFF_FE00}},          // R2 most negative
      {4{32'h0000_00A5}},          // R3
      {4{32'h0000_A500}},          // R3
      {4{32'h00A5_0000}},          // R3
      {4{32'hA500_0000}},          // R3
      {8{16'h00A5}},               // R4
      {8{16'hA500}},               // R4
      {4{32'h0000_A5FF}},          // R5
      {4{32'h00A5_FFFF}},          // R5
      {16{8'hA5}},                 // R6
      {2{64'hFF00_FF00_00FF_00FF}},// R7
      128'h0,                      // R7 empty mask
      {4{32'h3F80_0000}},          // R8
      {4{32'hC000_0000}},          // R8
      {2{64'h0000_0000_3F80_0000}},// R8 64-bit lanes
      {2{64'h3FF0_0000_0000_0000}},// R9
      {2{64'hC000_0000_0000_0000}},// R9
      128'h0, 128'h0, 128'h0       // R10
   };
   localparam logic EBAD_T [NV] = '{
      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
      1'b0, 1'b0, 1'b1, 1'b1, 1'b1
   };
   localparam logic [23:0] TAG_T [NV] = '{
      "R1", "R1", "R2", "R2", "R2", "R2", "R3", "R3", "R3", "R3",
      "R4", "R4", "R5", "R5", "R6", "R7", "R7", "R8", "R8", "R8",
      "R9", "R9", "R10", "R10", "R10"
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [12:0]  in_imm = '0;
   logic         out_valid;
   logic [127:0] out_vec;
   logic         out_illegal;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   simd_imm_expand dut (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .in_imm      (in_imm),
      .out_valid   (out_valid),
      .out_vec     (out_vec),
      .out_illegal (out_illegal)
   );

   task automatic chk(input bit ok, input logic [23:0] tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // reset state: R11
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R11", "valid in reset", 128'(out_valid), 128'h0);
      chk(out_illegal == 1'b0, "R11", "illegal in reset", 128'(out_illegal), 128'h0);
      rst = 1'b0;

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_imm   = IMM_T[i];
         @(negedge clk);
         chk(out_valid == 1'b1, TAG_T[i], "valid one cycle later", 128'(out_valid), 128'h1);
         chk(out_vec == EXP_T[i], TAG_T[i], "vector", out_vec, EXP_T[i]);
         chk(out_illegal == EBAD_T[i], TAG_T[i], "illegal flag", 128'(out_illegal), 128'(EBAD_T[i]));
         in_valid = 1'b0;
         in_imm   = ~IMM_T[i];
         @(negedge clk);
         chk(out_valid == 1'b0, "R11", "valid drops", 128'(out_valid), 128'h0);
         chk(out_vec == EXP_T[i], "R12", "hold without strobe", out_vec, EXP_T[i]);
         chk(out_illegal == 1'b0, "R10", "flag drops with valid", 128'(out_illegal), 128'h0);
      end

      // back-to-back strobes: R11
      @(negedge clk);
      in_valid = 1'b1; in_imm = 13'h13A5;
      @(negedge clk);
      chk(out_vec == {4{32'hA500_0000}}, "R11", "first of pair", out_vec, {4{32'hA500_0000}});
      in_imm = 13'h1D00;
      @(negedge clk);
      chk(out_vec == 128'h0 && out_illegal, "R11", "second of pair", out_vec, 128'h0);
      chk(out_valid == 1'b1, "R11", "valid stays high", 128'(out_valid), 128'h1);
      in_imm = 13'h0055;
      @(negedge clk);
      chk(out_vec == {16{8'h55}} && !out_illegal, "R11", "third of run", out_vec, {16{8'h55}});

      // strobe dropped while in reset: R11
      in_imm = 13'h1FFF;
      rst = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R11", "strobe during reset", 128'(out_valid), 128'h0);
      chk(out_illegal == 1'b0, "R11", "flag during reset", 128'(out_illegal), 128'h0);
      in_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R11", "no result after reset", 128'(out_valid), 128'h0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule